// File: doc/BRIEF.md
# Dual-Channel Multi-Format Sample Serializer

This block turns parallel 12-bit samples from several converter channels into narrow serial streams. Each channel gets one or two output lanes. A data clock and a frame clock go out alongside them. A fast bit clock drives the block, and every rising edge of it is one serial bit period. The outgoing data clock toggles once per bit period, so a receiver sees a new bit on each of its edges, rising and falling.

A 3-bit format code sets three things: how many lanes each channel uses, how long a frame is, and where the zero-valued padding bits go. In two-lane formats the odd-numbered sample bits go out on lane A and the even-numbered bits go out on lane B in step with them. In one-lane formats the whole word goes out MSB-first on lane A, and lane B is held low.

The block marks the bit period in which it captures the next input sample with a strobe. A captured sample is transmitted a fixed number of frames later. A format change only takes effect at a frame boundary. An output-disable input forces every serial output low while the internal timing keeps running.

Top module: `adc_lane_serializer`

## Requirements
- R1: The frame length in bit periods depends on `mode_sel`. Code 000 gives 8 bit periods (two lanes). Code 001 gives 7 (two lanes). Code 010 gives 6 (two lanes). Code 101 gives 14 (one lane). Code 110 gives 12 (one lane). Code 111 gives 16 (one lane). Codes 011 and 100 act exactly like 000.
- R2: In two-lane formats, lane A sends sample bits 11, 9, 7, 5, 3, 1 in frame bit periods 0 to 5. Lane B sends bits 10, 8, 6, 4, 2, 0 in the same periods. Any remaining periods of the frame (one in the 7-period format, two in the 8-period format) carry 0 on both lanes. Each channel uses its own sample.
- R3: In one-lane formats, lane A sends sample bits 11 down to 0 in frame bit periods 0 to 11, then 0 for any remaining periods. Lane B stays 0 for the whole frame.
- R4: While outputs are enabled, `dco` changes value every bit period. It is 1 in the first bit period after reset, and is therefore 1 in every even-numbered bit period counted from reset.
- R5: `fr` is 1 for the first floor(L/2) bit periods of a frame of length L and 0 for the rest. Its rising edge therefore coincides with bit 0 of a frame.
- R6: The format of a new frame is the value `mode_sel` holds in the bit period where `smp_take` is 1. Changes of `mode_sel` at any other time do not alter the frame in progress.
- R7: `smp_take` is 1 in exactly one bit period per frame: the one that carries output bit L-2 of that frame. All channel inputs are captured at the clock edge that ends that period.
- R8: A sample captured at the edge ending frame k is transmitted in frame k+1+PIPE_DEPTH. Frames that have no captured sample behind them carry an all-zero word.
- R9: When `out_off` is 1 at a clock edge, every lane, `dco` and `fr` are 0 in the following bit period. Frame timing, capture and `smp_take` keep running.
- R10: While `rst` is 1, all lanes, `dco`, `fr` and `smp_take` are 0. The first frame after reset uses code 000 and carries a zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock: one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Output format code |
| out_off | input | 1 | Forces all serial outputs low |
| ch_smp | input | NUM_CH x 12 | Parallel sample word of each channel |
| lane_a | output | NUM_CH | Lane A serial bit of each channel |
| lane_b | output | NUM_CH | Lane B serial bit of each channel |
| dco | output | 1 | Data clock, toggles once per bit period |
| fr | output | 1 | Frame clock, high in the first half of a frame |
| smp_take | output | 1 | High in the period whose ending edge captures the inputs |

## Verification
The assertions check several properties on every cycle:
- the bit counter never passes the end of the current frame, even across format changes;
- the capture strobe lines up with the frame end;
- the active format stays fixed inside a frame;
- the data clock keeps toggling;
- lane B stays low in one-lane formats;
- the frame clock is high at the start of each frame;
- the disable input silences all outputs.

Only the bench scenarios can show the rest. These are the exact bit order and padding in every format, the pairing of each transmitted word with the sample captured the right number of frames earlier, and the format chosen when `mode_sel` changes in the middle of a frame. The bench covers them by sweeping all eight codes under a changing sample stream, with disable windows inserted.

// File: rtl/ser_pkg.sv
package ser_pkg;

  localparam int SMP_W = 12;
  localparam int HALF  = SMP_W / 2;
  localparam int IW    = $clog2(SMP_W + 5);
  localparam int BW    = $clog2(SMP_W);

  typedef logic [IW-1:0] idx_t;

  typedef enum logic [2:0] {
    FMT_2L16 = 3'b000,
    FMT_2L14 = 3'b001,
    FMT_2L12 = 3'b010,
    FMT_1L14 = 3'b101,
    FMT_1L12 = 3'b110,
    FMT_1L16 = 3'b111
  } fmt_e;

  function automatic fmt_e decode_fmt(input logic [2:0] code);
    case (code)
      3'b001:  return FMT_2L14;
      3'b010:  return FMT_2L12;
      3'b101:  return FMT_1L14;
      3'b110:  return FMT_1L12;
      3'b111:  return FMT_1L16;
      default: return FMT_2L16;
    endcase
  endfunction

  function automatic idx_t frame_len(input fmt_e f);
    case (f)
      FMT_2L14: return idx_t'(HALF + 1);
      FMT_2L12: return idx_t'(HALF);
      FMT_1L16: return idx_t'(SMP_W + 4);
      FMT_1L14: return idx_t'(SMP_W + 2);
      FMT_1L12: return idx_t'(SMP_W);
      default:  return idx_t'(HALF + 2);
    endcase
  endfunction

  function automatic logic single_lane(input fmt_e f);
    return (f == FMT_1L16) || (f == FMT_1L14) || (f == FMT_1L12);
  endfunction

endpackage

// File: rtl/ser_frame_timer.sv
module ser_frame_timer
  import ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_sel,
  output idx_t       idx,
  output fmt_e       fmt,
  output logic       wrap,
  output logic       take
);

  idx_t idx_q;
  fmt_e fmt_q;
  logic take_q;
  idx_t len_w;

  always_comb begin
    len_w = frame_len(fmt_q);
    wrap  = (idx_q == idx_t'(len_w - idx_t'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      fmt_q  <= FMT_2L16;
      take_q <= 1'b0;
    end else if (wrap) begin
      idx_q  <= '0;
      fmt_q  <= decode_fmt(mode_sel);
      take_q <= 1'b0;
    end else begin
      idx_q  <= idx_q + idx_t'(1);
      take_q <= (idx_t'(idx_q + idx_t'(1)) == idx_t'(len_w - idx_t'(1)));
    end
  end

  assign idx  = idx_q;
  assign fmt  = fmt_q;
  assign take = take_q;

  // R1: counter stays inside the frame of the active format
  assert_idx_bound_R1: assert property (@(posedge clk) disable iff (rst)
    idx_q < frame_len(fmt_q));

  // R7: capture strobe sits on the last counter state of the frame
  assert_take_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    take_q == wrap);

  // R6: format is frozen inside a frame
  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(fmt_q));

endmodule

// File: rtl/ser_sample_pipe.sv
module ser_sample_pipe
  import ser_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [SMP_W-1:0] din,
  output logic [SMP_W-1:0] cur
);

  localparam int NSTG = DEPTH + 1;

  logic [SMP_W-1:0] stg [NSTG];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else if (adv) stg[0] <= din;
  end

  for (genvar i = 1; i < NSTG; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else if (adv) stg[i] <= stg[i-1];
    end
  end

  assign cur = stg[NSTG-1];

endmodule

// File: rtl/ser_lane_mux.sv
module ser_lane_mux
  import ser_pkg::*;
(
  input  idx_t             idx,
  input  fmt_e             fmt,
  input  logic [SMP_W-1:0] word,
  output logic             bit_a,
  output logic             bit_b
);

  logic [BW-1:0] sel_a;
  logic [BW-1:0] sel_b;
  int            p;

  always_comb begin
    p     = int'(idx);
    bit_a = 1'b0;
    bit_b = 1'b0;
    sel_a = '0;
    sel_b = '0;
    if (single_lane(fmt)) begin
      if (p < SMP_W) begin
        sel_a = BW'(SMP_W - 1 - p);
        bit_a = word[sel_a];
      end
    end else begin
      if (p < HALF) begin
        sel_a = BW'(SMP_W - 1 - 2 * p);
        sel_b = BW'(SMP_W - 2 - 2 * p);
        bit_a = word[sel_a];
        bit_b = word[sel_b];
      end
    end
  end

endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
  import ser_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int PIPE_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [2:0]                   mode_sel,
  input  logic                         out_off,
  input  logic [NUM_CH-1:0][SMP_W-1:0] ch_smp,
  output logic [NUM_CH-1:0]            lane_a,
  output logic [NUM_CH-1:0]            lane_b,
  output logic                         dco,
  output logic                         fr,
  output logic                         smp_take
);

  idx_t idx_w;
  fmt_e fmt_w;
  logic wrap_w;
  logic take_w;
  idx_t len_w;

  logic [NUM_CH-1:0] a_w;
  logic [NUM_CH-1:0] b_w;

  logic [NUM_CH-1:0] lane_a_q;
  logic [NUM_CH-1:0] lane_b_q;
  logic              dco_q;
  logic              fr_q;
  logic              phase_q;

  ser_frame_timer u_timer (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .idx      (idx_w),
    .fmt      (fmt_w),
    .wrap     (wrap_w),
    .take     (take_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SMP_W-1:0] word_w;

    ser_sample_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
      .clk (clk),
      .rst (rst),
      .adv (wrap_w),
      .din (ch_smp[c]),
      .cur (word_w)
    );

    ser_lane_mux u_mux (
      .idx   (idx_w),
      .fmt   (fmt_w),
      .word  (word_w),
      .bit_a (a_w[c]),
      .bit_b (b_w[c])
    );
  end

  assign len_w = frame_len(fmt_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_a_q <= '0;
      lane_b_q <= '0;
      dco_q    <= 1'b0;
      fr_q     <= 1'b0;
      phase_q  <= 1'b0;
    end else begin
      phase_q  <= ~phase_q;
      dco_q    <= ~out_off & ~phase_q;
      fr_q     <= ~out_off & (idx_w < (len_w >> 1));
      lane_a_q <= out_off ? '0 : a_w;
      lane_b_q <= out_off ? '0 : b_w;
    end
  end

  assign lane_a   = lane_a_q;
  assign lane_b   = lane_b_q;
  assign dco      = dco_q;
  assign fr       = fr_q;
  assign smp_take = take_w;

  // R9: disable silences every serial output one bit period later
  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    out_off |=> (lane_a_q == '0 && lane_b_q == '0 && !dco_q && !fr_q));

  // R4: data clock alternates while enabled
  assert_dco_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    (!out_off && !$past(out_off)) |=> (dco_q != $past(dco_q)));

  // R3: second lane idle in single-lane formats
  assert_lane_b_idle_R3: assert property (@(posedge clk) disable iff (rst)
    single_lane(fmt_w) |=> (lane_b_q == '0));

  // R5: frame clock is high on the first bit of each frame
  assert_fr_lead_R5: assert property (@(posedge clk) disable iff (rst)
    (idx_w == '0 && !out_off) |=> fr_q);

endmodule

// File: tb/adc_lane_serializer_tb.sv
module adc_lane_serializer_tb;

  localparam int CLK_P  = 10;
  localparam int NCH    = 2;
  localparam int DEPTH  = 4;
  localparam int NCYC   = 3600;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [2:0]            mode_sel = 3'b000;
  logic                  out_off = 1'b0;
  logic [NCH-1:0][11:0]  ch_smp = '0;
  logic [NCH-1:0]        lane_a;
  logic [NCH-1:0]        lane_b;
  logic                  dco;
  logic                  fr;
  logic                  smp_take;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  adc_lane_serializer #(.NUM_CH(NCH), .PIPE_DEPTH(DEPTH)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .out_off  (out_off),
    .ch_smp   (ch_smp),
    .lane_a   (lane_a),
    .lane_b   (lane_b),
    .dco      (dco),
    .fr       (fr),
    .smp_take (smp_take)
  );

  function automatic int norm_code(input logic [2:0] c);
    if (c == 3'b011 || c == 3'b100) return 0;
    return int'(c);
  endfunction

  // R1 frame lengths
  function automatic int len_of(input int c);
    case (c)
      1: return 7;
      2: return 6;
      5: return 14;
      6: return 12;
      7: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic bit one_lane(input int c);
    return c >= 5;
  endfunction

  function automatic logic [1:0] exp_bits(input int c, input int pos, input logic [11:0] w);
    logic a, b;
    a = 1'b0; b = 1'b0;
    if (one_lane(c)) begin
      if (pos < 12) a = w[11 - pos];
    end else if (pos < 6) begin
      a = w[11 - 2 * pos];
      b = w[10 - 2 * pos];
    end
    return {a, b};
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] cap [NCH][1024];
    logic [11:0] exp_word [NCH];
    logic [11:0] pend_word [NCH];
    logic [31:0] lfsr;
    int          pend_mode, exp_mode, exp_len, pos, k;
    logic [1:0]  eb;
    string       ltag;

    lfsr = 32'h1234_5678;
    for (int c = 0; c < NCH; c++) begin
      exp_word[c] = '0;
      pend_word[c] = '0;
    end
    pend_mode = 0; exp_mode = 0; exp_len = 8; pos = 0; k = 0;

    // R10 reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        check("R10 lane_a in reset", lane_a[c], 1'b0);
        check("R10 lane_b in reset", lane_b[c], 1'b0);
      end
      check("R10 dco in reset", dco, 1'b0);
      check("R10 fr in reset", fr, 1'b0);
      check("R10 smp_take in reset", smp_take, 1'b0);
    end
    rst = 1'b0;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      if (pos == exp_len) begin
        pos      = 0;
        exp_mode = pend_mode;
        exp_len  = len_of(pend_mode);
        for (int c = 0; c < NCH; c++) exp_word[c] = pend_word[c];
      end

      // lane checks also cover R1 R6 R8 (format and word of each frame)
      for (int c = 0; c < NCH; c++) begin
        eb = exp_bits(exp_mode, pos, exp_word[c]);
        if (out_off) ltag = "R9 lane forced low";
        else if (one_lane(exp_mode)) ltag = "R3/R6/R8 single-lane bit";
        else ltag = "R2/R6/R8 dual-lane bit";
        check({ltag, " A"}, lane_a[c], out_off ? 1'b0 : eb[1]);
        check({ltag, " B"}, lane_b[c], out_off ? 1'b0 : eb[0]);
      end
      check(out_off ? "R9 dco forced low" : "R4 dco phase", dco,
            (!out_off && (cyc % 2 == 0)) ? 1'b1 : 1'b0);
      check(out_off ? "R9 fr forced low" : "R5 frame clock", fr,
            (!out_off && pos < exp_len / 2) ? 1'b1 : 1'b0);
      check("R1/R7 capture strobe position", smp_take,
            (pos == exp_len - 2) ? 1'b1 : 1'b0);
      pos++;

      // stimulus for the coming edge
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      if (cyc % 97 < 12) begin
        ch_smp[0] = (cyc % 2 == 0) ? 12'hFFF : 12'hAAA;
        ch_smp[1] = (cyc % 2 == 0) ? 12'h000 : 12'h555;
      end else begin
        ch_smp[0] = lfsr[11:0];
        ch_smp[1] = lfsr[27:16];
      end
      if (cyc < 2400) mode_sel = 3'((cyc / 41) % 8);
      else mode_sel = 3'(((cyc - 2400) / 130) % 8);
      out_off = ((cyc >= 1500 && cyc < 1530) || (cyc >= 2800 && cyc < 2803)) ? 1'b1 : 1'b0;

      // R6 R7: inputs seen at the end of a strobe period are captured
      if (smp_take) begin
        pend_mode = norm_code(mode_sel);
        for (int c = 0; c < NCH; c++) begin
          cap[c][k] = ch_smp[c];
          pend_word[c] = (k >= DEPTH) ? cap[c][k - DEPTH] : 12'h000;
        end
        k++;
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule